// File: doc/BRIEF.md
# Flash Streaming Program Sequencer

This block is the command-driven write sequencer of a NOR-style flash device. The host issues bus write cycles; the low byte of the data carries a command when the sequencer is idle or waiting for a confirm, and the whole word is payload when it is collecting data. A streaming factory-programming mode moves through three phases: a setup write that names a first-word address, a confirm that opens the program/verify phase, and an exit taken when the host writes to any other address. In the program/verify phase the host keeps writing to that same first-word address. Each group of 32 words is collected in a write buffer and committed to an internal word array. The internal pointer then moves on to the next 32-word boundary by itself.

A simpler buffered-program command (address, word count, data, confirm) shares the buffer and the commit engine. It is checked for voltage, lock and block-span errors before any data is accepted. A status byte reports ready and busy along with sticky error flags, which a clear-status command resets. Lock state per erase block and a program-voltage-good flag arrive as inputs. The array can be read at any time through a separate read address.

Top module: `flash_wsm`

## Requirements
- R1: After reset the status byte is 0x80: bit 7 (ready) high, bit 0 (commit busy) low, and error bits 5, 4, 3 and 1 low.
- R2: Status layout is bit 7 ready, bit 5 sequence error, bit 4 program error, bit 3 voltage error, bit 1 lock error, bit 0 commit busy. Writing 0x50 while idle clears bits 5, 4, 3 and 1. Error bits clear only through that command, and any other idle byte (such as 0xFF) changes nothing.
- R3: A write of 0x80 latches its address as the first-word address. A following write of 0xD0 enters the data phase. Bit 7 stays high while the sequencer waits for a confirm or for data.
- R4: The write buffer holds 32 words. A commit starts on the write of the 32nd word and never earlier.
- R5: Each commit lasts exactly 64 cycles with bit 0 high and bit 7 low. Afterwards, array word base+i holds buffer word i.
- R6: In the data phase every buffer after the first lands 32 words above the previous one, while the host keeps presenting the first-word address.
- R7: In the data phase, a write to an address other than the first-word address ends the mode with no error. Any partly filled buffer is dropped and not written to the array.
- R8: Writes that arrive during a commit are ignored, including a suspend byte 0xB0 and writes to other addresses. A write in the final commit cycle is also ignored.
- R9: If the voltage-good input is low at confirm or at word count, bits 4 and 3 are set and the operation is abandoned. This check takes priority over the lock and sequence checks.
- R10: If the erase block holding the target address is locked (lockMask bit = block number, block = address bits 11:10), bits 4 and 1 are set and the operation is abandoned.
- R11: A streaming first-word address that is not a multiple of 32, or a confirm byte other than 0xD0, sets bits 5 and 4 and returns to idle.
- R12: Erase blocks are 1024 words. A buffered program whose offset plus count exceeds 1024 is aborted. So is a streaming data write after the pointer has left the first-word address's block. Both set bits 5 and 4.
- R13: 0xE8 at address A, then a count write whose low 5 bits are N-1, then N data words, then 0xD0, commits those N words to A..A+N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe, one write per cycle |
| wrAddr | input | 12 | Write address |
| wrData | input | 16 | Write data; low byte is the command |
| vppOk | input | 1 | Program voltage good |
| lockMask | input | 4 | Lock flag per 1024-word erase block |
| rdAddr | input | 12 | Array read address |
| rdData | output | 16 | Array word at rdAddr |
| status | output | 8 | Status byte |

## Verification
The end of a commit can coincide with a host write: in the last busy cycle, the pointer advances and the buffer empties while a write sits on the bus. The bench places a suspend byte at the first-word address in exactly that cycle, and earlier places a write to a foreign address mid-commit. It then judges the result by whether the next buffer's commit starts on its 32nd word rather than its 31st, and by where that buffer lands in the array. Voltage, lock and alignment faults also collide at a single confirm write, and the bench checks that only the voltage bits appear.

// File: rtl/flash_wsm_pkg.sv
package flash_wsm_pkg;
  localparam logic [7:0] CMD_STREAM  = 8'h80;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLRSTAT = 8'h50;
  localparam logic [7:0] CMD_BUFPGM  = 8'hE8;

  // control-to-datapath strobes
  typedef struct packed {
    logic latchBase;   // capture wrAddr as first-word address and pointer
    logic lenFull;     // buffer length = full buffer
    logic lenLoad;     // buffer length from count write
    logic bufClr;      // empty the buffer
    logic bufPush;     // append wrData to the buffer
    logic commitStep;  // one commit cycle
    logic commitDone;  // last commit cycle
    logic setSeq;
    logic setVpp;
    logic setLock;
    logic clrErr;
    logic busy;
  } wsm_stb_t;
endpackage

// File: rtl/wsm_datapath.sv
module wsm_datapath
  import flash_wsm_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  parameter int BUF_WORDS   = 32,
  parameter int BLOCK_WORDS = 1024
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  wsm_stb_t                            stb,
  input  logic [ADDR_W-1:0]                   wrAddr,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic [(2**ADDR_W)/BLOCK_WORDS-1:0]  lockMask,
  input  logic [ADDR_W-1:0]                   rdAddr,
  output logic [DATA_W-1:0]                   rdData,
  output logic [7:0]                          status,
  output logic                                addrHit,
  output logic                                ptrAligned,
  output logic                                tgtLocked,
  output logic                                lastWord,
  output logic                                legacyCross,
  output logic                                ptrOutBlock
);
  localparam int ARRAY_WORDS = 2**ADDR_W;
  localparam int CW          = $clog2(BUF_WORDS + 1);
  localparam int BI_W        = $clog2(BUF_WORDS);
  localparam int OFF_W       = $clog2(BLOCK_WORDS);

  logic [ADDR_W-1:0] wa0, ptr;
  logic [CW-1:0]     fillCnt, bufLen, commitIdx, reqLen;
  logic [DATA_W-1:0] bufMem [BUF_WORDS];
  logic [DATA_W-1:0] arr    [ARRAY_WORDS];
  logic errSeq, errPgm, errVpp, errLock;

  assign reqLen      = CW'(wrData[BI_W-1:0]) + CW'(1);
  assign addrHit     = (wrAddr == wa0);
  assign ptrAligned  = (ptr[BI_W-1:0] == '0);
  assign tgtLocked   = lockMask[ptr[ADDR_W-1:OFF_W]];
  assign lastWord    = ((fillCnt + CW'(1)) == bufLen);
  assign legacyCross = ({1'b0, ptr[OFF_W-1:0]} + (OFF_W+1)'(reqLen)) > (OFF_W+1)'(BLOCK_WORDS);
  assign ptrOutBlock = (ptr[ADDR_W-1:OFF_W] != wa0[ADDR_W-1:OFF_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wa0 <= '0; ptr <= '0; fillCnt <= '0; bufLen <= '0; commitIdx <= '0;
      errSeq <= 1'b0; errPgm <= 1'b0; errVpp <= 1'b0; errLock <= 1'b0;
    end else begin
      if (stb.latchBase) begin
        wa0 <= wrAddr;
        ptr <= wrAddr;
      end
      if (stb.lenFull) bufLen <= CW'(BUF_WORDS);
      else if (stb.lenLoad) bufLen <= reqLen;
      if (stb.bufClr) fillCnt <= '0;
      else if (stb.bufPush) fillCnt <= fillCnt + CW'(1);
      if (stb.commitDone) begin
        commitIdx <= '0;
        fillCnt   <= '0;
        ptr       <= ptr + ADDR_W'(BUF_WORDS);
      end else if (stb.commitStep && commitIdx != bufLen) begin
        commitIdx <= commitIdx + CW'(1);
      end
      if (stb.clrErr) begin
        errSeq <= 1'b0; errPgm <= 1'b0; errVpp <= 1'b0; errLock <= 1'b0;
      end else begin
        if (stb.setSeq)  begin errSeq  <= 1'b1; errPgm <= 1'b1; end
        if (stb.setVpp)  begin errVpp  <= 1'b1; errPgm <= 1'b1; end
        if (stb.setLock) begin errLock <= 1'b1; errPgm <= 1'b1; end
      end
    end
  end

  // storage without reset
  always_ff @(posedge clk) begin
    if (stb.bufPush) bufMem[fillCnt[BI_W-1:0]] <= wrData;
    if (stb.commitStep && commitIdx < bufLen)
      arr[ptr + ADDR_W'(commitIdx)] <= bufMem[commitIdx[BI_W-1:0]];
  end

  assign rdData = arr[rdAddr];
  assign status = {~stb.busy, 1'b0, errSeq, errPgm, errVpp, 1'b0, errLock, stb.busy};
endmodule

// File: rtl/wsm_ctrl.sv
module wsm_ctrl
  import flash_wsm_pkg::*;
#(
  parameter int COMMIT_CYCLES = 64
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrEn,
  input  logic [7:0] cmd,
  input  logic     vppOk,
  input  logic     addrHit,
  input  logic     ptrAligned,
  input  logic     tgtLocked,
  input  logic     lastWord,
  input  logic     legacyCross,
  input  logic     ptrOutBlock,
  output wsm_stb_t stb
);
  localparam int TW = $clog2(COMMIT_CYCLES);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCONF, ST_FILL, ST_COMMIT, ST_LCNT, ST_LFILL, ST_LCONF
  } wsm_state_e;

  wsm_state_e state, nxt;
  logic [TW-1:0] cycCnt;
  logic streamMode;

  always_comb begin
    stb      = '0;
    nxt      = state;
    stb.busy = (state == ST_COMMIT);
    case (state)
      ST_IDLE: if (wrEn) begin
        if (cmd == CMD_CLRSTAT) stb.clrErr = 1'b1;
        else if (cmd == CMD_STREAM) begin stb.latchBase = 1'b1; nxt = ST_SCONF; end
        else if (cmd == CMD_BUFPGM) begin stb.latchBase = 1'b1; nxt = ST_LCNT; end
      end
      ST_SCONF: if (wrEn) begin
        nxt = ST_IDLE;
        if (cmd != CMD_CONFIRM) stb.setSeq = 1'b1;
        else if (!vppOk)        stb.setVpp = 1'b1;
        else if (tgtLocked)     stb.setLock = 1'b1;
        else if (!ptrAligned)   stb.setSeq = 1'b1;
        else begin
          stb.lenFull = 1'b1;
          stb.bufClr  = 1'b1;
          nxt = ST_FILL;
        end
      end
      ST_FILL: if (wrEn) begin
        if (!addrHit) begin
          stb.bufClr = 1'b1;
          nxt = ST_IDLE;
        end else if (ptrOutBlock) begin
          stb.setSeq = 1'b1;
          nxt = ST_IDLE;
        end else begin
          stb.bufPush = 1'b1;
          if (lastWord) nxt = ST_COMMIT;
        end
      end
      ST_COMMIT: begin
        stb.commitStep = 1'b1;
        if (cycCnt == TW'(COMMIT_CYCLES - 1)) begin
          stb.commitDone = 1'b1;
          nxt = streamMode ? ST_FILL : ST_IDLE;
        end
      end
      ST_LCNT: if (wrEn) begin
        nxt = ST_IDLE;
        if (!vppOk)           stb.setVpp = 1'b1;
        else if (tgtLocked)   stb.setLock = 1'b1;
        else if (legacyCross) stb.setSeq = 1'b1;
        else begin
          stb.lenLoad = 1'b1;
          stb.bufClr  = 1'b1;
          nxt = ST_LFILL;
        end
      end
      ST_LFILL: if (wrEn) begin
        stb.bufPush = 1'b1;
        if (lastWord) nxt = ST_LCONF;
      end
      ST_LCONF: if (wrEn) begin
        if (cmd == CMD_CONFIRM) nxt = ST_COMMIT;
        else begin
          stb.setSeq = 1'b1;
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cycCnt     <= '0;
      streamMode <= 1'b0;
    end else begin
      state  <= nxt;
      cycCnt <= (state == ST_COMMIT) ? cycCnt + TW'(1) : '0;
      if (state == ST_SCONF && nxt == ST_FILL) streamMode <= 1'b1;
      else if (state == ST_LCONF && nxt == ST_COMMIT) streamMode <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
  import flash_wsm_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 16,
  parameter int BUF_WORDS     = 32,
  parameter int BLOCK_WORDS   = 1024,
  parameter int COMMIT_CYCLES = 64
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               wrEn,
  input  logic [ADDR_W-1:0]                  wrAddr,
  input  logic [DATA_W-1:0]                  wrData,
  input  logic                               vppOk,
  input  logic [(2**ADDR_W)/BLOCK_WORDS-1:0] lockMask,
  input  logic [ADDR_W-1:0]                  rdAddr,
  output logic [DATA_W-1:0]                  rdData,
  output logic [7:0]                         status
);
  wsm_stb_t stb;
  logic addrHit, ptrAligned, tgtLocked, lastWord, legacyCross, ptrOutBlock;

  wsm_ctrl #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .cmd(wrData[7:0]), .vppOk(vppOk),
    .addrHit(addrHit), .ptrAligned(ptrAligned), .tgtLocked(tgtLocked),
    .lastWord(lastWord), .legacyCross(legacyCross), .ptrOutBlock(ptrOutBlock),
    .stb(stb)
  );

  wsm_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS), .BLOCK_WORDS(BLOCK_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .wrData(wrData),
    .lockMask(lockMask), .rdAddr(rdAddr), .rdData(rdData), .status(status),
    .addrHit(addrHit), .ptrAligned(ptrAligned), .tgtLocked(tgtLocked),
    .lastWord(lastWord), .legacyCross(legacyCross), .ptrOutBlock(ptrOutBlock)
  );
endmodule

// File: rtl/flash_wsm_chk.sv
module flash_wsm_chk #(
  parameter int COMMIT_CYCLES = 64
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] cmdByte,
  input logic [7:0] status
);
  int busyLen;

  always_ff @(posedge clk) begin
    if (!rstN) busyLen <= 0;
    else busyLen <= status[0] ? busyLen + 1 : 0;
  end

  AST_COMMIT_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status[0]) |-> busyLen == COMMIT_CYCLES);  // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (status[4] && !(wrEn && cmdByte == 8'h50)) |=> status[4]);  // R2
  AST_VPP_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    status[3] |-> status[4]);  // R9
  AST_LOCK_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    status[1] |-> status[4]);  // R10
  AST_SEQ_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    status[5] |-> status[4]);  // R11
  AST_COMMIT_DEAF: assert property (@(posedge clk) disable iff (!rstN)
    (status[0] && wrEn) |=> $stable(status[5:1]));  // R8
endmodule

bind flash_wsm flash_wsm_chk #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .cmdByte(wrData[7:0]), .status(status)
);

// File: tb/tb_flash_wsm.sv
module tb_flash_wsm;
  logic        clk = 1'b0;
  logic        rstN, wrEn, vppOk;
  logic [11:0] wrAddr, rdAddr;
  logic [15:0] wrData, rdData;
  logic [3:0]  lockMask;
  logic [7:0]  status;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  flash_wsm dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .vppOk(vppOk), .lockMask(lockMask), .rdAddr(rdAddr), .rdData(rdData), .status(status)
  );

  // {req[3:0], vpp, addr[11:0], data[15:0], expected status[7:0]}; block 2 locked
  localparam int NV = 25;
  localparam logic [40:0] VEC [NV] = '{
    {4'd2,  1'b1, 12'h000, 16'h0050, 8'h80},  // R2 clear in clean state
    {4'd3,  1'b1, 12'h000, 16'h0080, 8'h80},  // R3 setup waits
    {4'd9,  1'b0, 12'h000, 16'h00D0, 8'h98},  // R9 voltage low at confirm
    {4'd2,  1'b1, 12'h000, 16'h00FF, 8'h98},  // R2 other byte keeps errors
    {4'd2,  1'b1, 12'h000, 16'h0050, 8'h80},  // R2 clear
    {4'd10, 1'b1, 12'h800, 16'h0080, 8'h80},
    {4'd10, 1'b1, 12'h800, 16'h00D0, 8'h92},  // R10 locked block
    {4'd2,  1'b1, 12'h000, 16'h0050, 8'h80},
    {4'd11, 1'b1, 12'h005, 16'h0080, 8'h80},
    {4'd11, 1'b1, 12'h005, 16'h00D0, 8'hB0},  // R11 unaligned
    {4'd2,  1'b1, 12'h000, 16'h0050, 8'h80},
    {4'd11, 1'b1, 12'h000, 16'h0080, 8'h80},
    {4'd11, 1'b1, 12'h000, 16'h0012, 8'hB0},  // R11 bad confirm
    {4'd2,  1'b1, 12'h000, 16'h0050, 8'h80},
    {4'd12, 1'b1, 12'h3F0, 16'h00E8, 8'h80},
    {4'd12, 1'b1, 12'h3F0, 16'h001F, 8'hB0},  // R12 1008+32 > 1024
    {4'd2,  1'b1, 12'h000, 16'h0050, 8'h80},
    {4'd9,  1'b1, 12'h3F0, 16'h00E8, 8'h80},
    {4'd9,  1'b0, 12'h3F0, 16'h0003, 8'h98},  // R9 voltage low at count
    {4'd2,  1'b1, 12'h000, 16'h0050, 8'h80},
    {4'd9,  1'b1, 12'h805, 16'h0080, 8'h80},
    {4'd9,  1'b0, 12'h805, 16'h00D0, 8'h98},  // R9 wins over lock and alignment
    {4'd2,  1'b1, 12'h000, 16'h0050, 8'h80},
    {4'd2,  1'b1, 12'h000, 16'h00FF, 8'h80},  // R2 read-array byte no effect
    {4'd2,  1'b1, 12'h123, 16'h0000, 8'h80}
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (status[0] && n < 1000) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  task automatic peek(input logic [11:0] a, input logic [15:0] exp, input string req);
    rdAddr = a; #1;
    check(rdData, exp, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int n;
    rstN = 1'b0; wrEn = 1'b0; vppOk = 1'b1; lockMask = 4'b0100;
    wrAddr = '0; wrData = '0; rdAddr = '0;
    repeat (3) @(posedge clk); #1;
    rstN = 1'b1;
    check(16'(status), 16'h0080, "R1 reset status");

    for (int i = 0; i < NV; i++) begin
      vppOk = VEC[i][36];
      wr(VEC[i][35:24], VEC[i][23:8]);
      check(16'(status), 16'(VEC[i][7:0]), $sformatf("R%0d table vector %0d", VEC[i][40:37], i));
    end
    vppOk = 1'b1;

    // R13 buffered program of 4 words at 0x100
    wr(12'h100, 16'h00E8);
    wr(12'h100, 16'h0003);
    for (int i = 0; i < 4; i++) wr(12'h100, 16'h5550 + 16'(i));
    check(16'(status), 16'h0080, "R13 waits for confirm");
    wr(12'h100, 16'h00D0);
    check(16'(status), 16'h0001, "R13 commit starts on confirm");
    waitIdle(n);
    check(16'(n), 16'd64, "R5 commit length buffered program");
    for (int i = 0; i < 4; i++) peek(12'h100 + 12'(i), 16'h5550 + 16'(i), "R13 array content");

    // streaming at 0x080
    wr(12'h080, 16'h0080);
    check(16'(status), 16'h0080, "R3 after setup");
    wr(12'h080, 16'h00D0);
    check(16'(status), 16'h0080, "R3 data phase ready");
    for (int i = 0; i < 32; i++) begin
      wr(12'h080, 16'hA000 + 16'(i));
      if (i == 30) check(16'(status), 16'h0080, "R4 no commit at 31 words");
    end
    check(16'(status), 16'h0001, "R5 busy after 32nd word");
    waitIdle(n);
    check(16'(n), 16'd64, "R5 commit length");
    for (int i = 0; i < 32; i++) wr(12'h080, 16'hB000 + 16'(i));
    waitIdle(n);
    check(16'(n), 16'd64, "R5 second commit length");
    for (int i = 0; i < 32; i += 31) begin
      peek(12'h080 + 12'(i), 16'hA000 + 16'(i), "R5 first buffer");
      peek(12'h0A0 + 12'(i), 16'hB000 + 16'(i), "R6 second buffer advanced");
    end

    // R8 writes during commit, one in the final busy cycle
    for (int i = 0; i < 32; i++) wr(12'h080, 16'hC000 + 16'(i));
    repeat (9) @(posedge clk); #1;
    wr(12'h7FF, 16'h00B0);   // foreign address mid-commit
    repeat (53) @(posedge clk); #1;
    check(16'(status), 16'h0001, "R8 still busy before last cycle");
    wr(12'h080, 16'h00B0);   // sampled in the last commit cycle
    check(16'(status), 16'h0080, "R8 commit ended, no error");
    for (int i = 0; i < 31; i++) wr(12'h080, 16'hD000 + 16'(i));
    check(16'(status), 16'h0080, "R8 ignored write not buffered");
    wr(12'h080, 16'hD01F);
    check(16'(status), 16'h0001, "R8 commit on 32nd new word");
    waitIdle(n);
    peek(12'h0C0, 16'hC000, "R6 third buffer start");
    peek(12'h0DF, 16'hC01F, "R6 third buffer end");
    peek(12'h0E0, 16'hD000, "R8 fourth buffer start");
    peek(12'h0FF, 16'hD01F, "R8 fourth buffer end");

    // R7 exit with a partial buffer, next pointer 0x100
    for (int i = 0; i < 5; i++) wr(12'h080, 16'hE000 + 16'(i));
    wr(12'h200, 16'h00FF);
    check(16'(status), 16'h0080, "R7 exit without error");
    repeat (70) @(posedge clk); #1;
    check(16'(status), 16'h0080, "R7 no commit after exit");
    peek(12'h100, 16'h5550, "R7 partial buffer dropped");
    wr(12'h080, 16'h1234);
    check(16'(status), 16'h0080, "R7 idle after exit");

    // R12 streaming runs off the block end
    wr(12'h3E0, 16'h0080);
    wr(12'h3E0, 16'h00D0);
    for (int i = 0; i < 32; i++) wr(12'h3E0, 16'hF000 + 16'(i));
    waitIdle(n);
    peek(12'h3E0, 16'hF000, "R12 last in-block buffer start");
    peek(12'h3FF, 16'hF01F, "R12 last in-block buffer end");
    wr(12'h3E0, 16'h4321);
    check(16'(status), 16'h00B0, "R12 cross-block data aborted");
    wr(12'h000, 16'h0050);
    check(16'(status), 16'h0080, "R2 final clear");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule